// File: doc/BRIEF.md
# Pixel Depth Unpacker

The unpacker sits between the frame fetch stream and the panel formatter of a display pipeline. It takes 32-bit words, each holding one or more pixels, and sends out one pixel per cycle. A single depth setting controls how each word is split. At 1, 2, 4 and 8 bits per pixel every field is an index into a 256-entry, 16-bit colour table, and the table entry becomes the pixel. At 15 and 16 bits two direct-colour pixels share a word. At any depth from 17 to 32 bits each word carries one pixel, and its low 24 bits are sent out.

The colour table has its own write port, so software can load it while pixels are being read. The depth setting can be written at any time. A write made while the pipeline holds data is stored and waits for the next frame-start pulse. That pulse also throws away any pixels left over from the previous frame.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset `px_valid` is 0, `in_ready` is 1, and the depth mode is 16 bits per pixel, so one word gives two pixels: its low half first, then its high half.
- R2: Pixels leave a word starting at the least significant bits and moving upward. One word gives 32/n pixels at n = 1, 2, 4 or 8, two pixels at 15 or 16, and one pixel at 17 to 32.
- R3: At 1, 2, 4 and 8 bits per pixel, each field is a colour-table address, and `px_data` is that 16-bit entry zero-extended to 24 bits.
- R4: At 16 bits per pixel, `px_data` is the 16-bit field zero-extended to 24 bits.
- R5: At 15 bits per pixel, each 16-bit half is read as red in bits 14..10, green in bits 9..5 and blue in bits 4..0, and bit 15 is ignored. `px_data` is {8'h00, red, green, green[4], blue}.
- R6: At any depth from 17 to 32, one pixel is sent per word and `px_data` equals bits 23..0 of the word.
- R7: Any depth value not named in R2 (0, 3, 5 to 7, 9 to 14, and above 32) behaves as 16 bits per pixel.
- R8: A colour-table write and a pixel read of the same entry in the same cycle give the pixel the entry's old value. The next read gives the new value.
- R9: While `px_valid` is 1 and `px_ready` is 0, `px_valid` stays 1 and `px_data` does not change. No pixel is lost or repeated.
- R10: A depth write while any word or pixel is held does not change how pixels are split until a `frame_start` pulse arrives. A depth write while idle applies to the next word.
- R11: `in_ready` is 0 while a word still has pixels waiting to be sent. After a `frame_start` pulse, the held word and the pending pixel are dropped, so `px_valid` is 0 and `in_ready` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Depth-setting write strobe |
| cfg_bpp | input | BPP_W (6) | Bits-per-pixel value, written as a plain number |
| frame_start | input | 1 | One-cycle pulse that starts a frame: applies a deferred depth write and flushes the pipeline |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with `in_valid` |
| in_data | input | 32 | Packed pixel word |
| pal_we | input | 1 | Colour-table write strobe |
| pal_addr | input | PAL_AW (8) | Colour-table write address |
| pal_data | input | PAL_W (16) | Colour-table write data |
| px_valid | output | 1 | Output pixel valid |
| px_ready | input | 1 | Downstream ready |
| px_data | output | PIX_W (24) | Output pixel |

## Verification
The assertions check four things on every cycle: the output stalls correctly under backpressure, the lane counter stays within the pixel count of the current mode, the mode stays frozen while the pipeline holds data, and a frame-start pulse leaves the pipeline empty. Only the bench scenarios can show the values of the pixels. That covers the colour-table contents for each indexed depth, the green-channel widening at 15 bits, the fall-back for unsupported depths, the low-to-high pixel order within a word, and the old-value result when a table write and a read meet on one entry.

// File: rtl/upk_pkg.sv
package upk_pkg;

  localparam int WORD_W = 32;
  localparam int LANE_W = $clog2(WORD_W);

  typedef enum logic [2:0] {
    DK_IDX1   = 3'd0,
    DK_IDX2   = 3'd1,
    DK_IDX4   = 3'd2,
    DK_IDX8   = 3'd3,
    DK_RGB555 = 3'd4,
    DK_RGB565 = 3'd5,
    DK_WORD   = 3'd6
  } depth_kind_e;

  // Map a numeric bits-per-pixel setting onto an unpacking kind.
  function automatic depth_kind_e decode_depth(input int unsigned bpp);
    depth_kind_e k;
    case (bpp)
      1:       k = DK_IDX1;
      2:       k = DK_IDX2;
      4:       k = DK_IDX4;
      8:       k = DK_IDX8;
      15:      k = DK_RGB555;
      16:      k = DK_RGB565;
      default: k = (bpp >= 17 && bpp <= 32) ? DK_WORD : DK_RGB565;
    endcase
    return k;
  endfunction

  // log2 of the number of word bits each pixel occupies.
  function automatic int unsigned field_log2(input depth_kind_e k);
    int unsigned r;
    case (k)
      DK_IDX1:   r = 0;
      DK_IDX2:   r = 1;
      DK_IDX4:   r = 2;
      DK_IDX8:   r = 3;
      DK_WORD:   r = 5;
      default:   r = 4;
    endcase
    return r;
  endfunction

  function automatic logic is_indexed(input depth_kind_e k);
    return (k == DK_IDX1) || (k == DK_IDX2) || (k == DK_IDX4) || (k == DK_IDX8);
  endfunction

  // Index of the last pixel lane in a word for the given kind.
  function automatic logic [LANE_W-1:0] last_lane(input depth_kind_e k);
    return LANE_W'((WORD_W >> field_log2(k)) - 1);
  endfunction

  // Pull lane `lane` out of `word`, least significant lane first.
  function automatic logic [WORD_W-1:0] slice_field(input logic [WORD_W-1:0] word,
                                                    input depth_kind_e k,
                                                    input logic [LANE_W-1:0] lane);
    int unsigned lg;
    int unsigned sh;
    logic [WORD_W-1:0] mask;
    lg = field_log2(k);
    sh = int'(lane) << lg;
    if (lg >= unsigned'(LANE_W)) mask = '1;
    else mask = (WORD_W'(1) << (1 << lg)) - WORD_W'(1);
    return (word >> sh) & mask;
  endfunction

  // 5-5-5 to 5-6-5: green gains a low bit copied from its top bit.
  function automatic logic [15:0] widen_555(input logic [15:0] h);
    return {h[14:10], h[9:5], h[9], h[4:0]};
  endfunction

endpackage

// File: rtl/upk_mode_reg.sv
module upk_mode_reg #(
  parameter int BPP_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [BPP_W-1:0]          cfg_bpp,
  input  logic                      frame_start,
  input  logic                      idle,
  output upk_pkg::depth_kind_e      active_kind
);
  import upk_pkg::*;

  depth_kind_e pending_q;
  depth_kind_e active_q;
  depth_kind_e written;

  assign written = decode_depth(32'(cfg_bpp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= DK_RGB565;
      active_q  <= DK_RGB565;
    end else begin
      if (cfg_we) begin
        pending_q <= written;
        if (idle || frame_start) active_q <= written;
      end else if (frame_start) begin
        active_q <= pending_q;
      end
    end
  end

  assign active_kind = active_q;

endmodule

// File: rtl/upk_word_slicer.sv
module upk_word_slicer #(
  parameter int FW = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  upk_pkg::depth_kind_e          kind,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [upk_pkg::WORD_W-1:0]    in_data,
  input  logic                          take,
  output logic                          hold_valid,
  output logic [upk_pkg::LANE_W-1:0]    lane,
  output logic                          lane_last,
  output logic [FW-1:0]                 field
);
  import upk_pkg::*;

  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;
  logic              valid_q;
  logic              accept;

  assign lane_last = (lane_q == last_lane(kind));
  assign in_ready  = !flush && (!valid_q || (take && lane_last));
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      lane_q  <= '0;
      valid_q <= 1'b0;
    end else if (flush) begin
      valid_q <= 1'b0;
      lane_q  <= '0;
    end else if (accept) begin
      word_q  <= in_data;
      lane_q  <= '0;
      valid_q <= 1'b1;
    end else if (take) begin
      if (lane_last) valid_q <= 1'b0;
      else lane_q <= lane_q + LANE_W'(1);
    end
  end

  assign hold_valid = valid_q;
  assign lane       = lane_q;
  assign field      = FW'(slice_field(word_q, kind, lane_q));

endmodule

// File: rtl/upk_palette_ram.sv
module upk_palette_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read; same-edge write is not visible until the next read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/upk_out_stage.sv
module upk_out_stage #(
  parameter int PAL_W = 16,
  parameter int PIX_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  load,
  input  upk_pkg::depth_kind_e  kind,
  input  logic [PIX_W-1:0]      field,
  input  logic [PAL_W-1:0]      pal_q,
  input  logic                  px_ready,
  output logic                  px_valid,
  output logic [PIX_W-1:0]      px_data
);
  import upk_pkg::*;

  logic             valid_q;
  logic             use_pal_q;
  logic [PIX_W-1:0] direct_q;
  logic [PIX_W-1:0] direct_d;

  always_comb begin
    case (kind)
      DK_RGB555: direct_d = PIX_W'(widen_555(field[15:0]));
      DK_WORD:   direct_d = field;
      default:   direct_d = PIX_W'(field[15:0]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      use_pal_q <= 1'b0;
      direct_q  <= '0;
    end else begin
      if (flush) valid_q <= 1'b0;
      else if (load) valid_q <= 1'b1;
      else if (px_ready) valid_q <= 1'b0;
      if (load) begin
        use_pal_q <= is_indexed(kind);
        direct_q  <= direct_d;
      end
    end
  end

  assign px_valid = valid_q;
  assign px_data  = use_pal_q ? PIX_W'(pal_q) : direct_q;

endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker #(
  parameter int BPP_W  = 6,
  parameter int PAL_AW = 8,
  parameter int PAL_W  = 16,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BPP_W-1:0]  cfg_bpp,
  input  logic              frame_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic              pal_we,
  input  logic [PAL_AW-1:0] pal_addr,
  input  logic [PAL_W-1:0]  pal_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [PIX_W-1:0]  px_data
);
  import upk_pkg::*;

  // Named internal events, also watched by the bound checker.
  depth_kind_e         active_kind;
  logic                hold_valid;
  logic [LANE_W-1:0]   lane;
  logic                lane_last;
  logic [PIX_W-1:0]    field;
  logic [PAL_W-1:0]    pal_q;
  logic                adv;
  logic                idle;
  logic                pal_re;

  assign idle   = !hold_valid && !px_valid;
  assign adv    = hold_valid && (!px_valid || px_ready) && !frame_start;
  assign pal_re = adv && is_indexed(active_kind);

  upk_mode_reg #(.BPP_W(BPP_W)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_bpp     (cfg_bpp),
    .frame_start (frame_start),
    .idle        (idle),
    .active_kind (active_kind)
  );

  upk_word_slicer #(.FW(PIX_W)) u_slice (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (frame_start),
    .kind       (active_kind),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .take       (adv),
    .hold_valid (hold_valid),
    .lane       (lane),
    .lane_last  (lane_last),
    .field      (field)
  );

  upk_palette_ram #(.AW(PAL_AW), .DW(PAL_W)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pal_we),
    .waddr (pal_addr),
    .wdata (pal_data),
    .re    (pal_re),
    .raddr (field[PAL_AW-1:0]),
    .rdata (pal_q)
  );

  upk_out_stage #(.PAL_W(PAL_W), .PIX_W(PIX_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (frame_start),
    .load     (adv),
    .kind     (active_kind),
    .field    (field),
    .pal_q    (pal_q),
    .px_ready (px_ready),
    .px_valid (px_valid),
    .px_data  (px_data)
  );

endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk #(
  parameter int PIX_W = 24
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       frame_start,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       px_valid,
  input logic                       px_ready,
  input logic [PIX_W-1:0]           px_data,
  input logic                       hold_valid,
  input logic [upk_pkg::LANE_W-1:0] lane,
  input logic                       idle,
  input upk_pkg::depth_kind_e       active_kind
);
  import upk_pkg::*;

  function automatic int unsigned lanes_of(input depth_kind_e k);
    case (k)
      DK_IDX1:   return 32;
      DK_IDX2:   return 16;
      DK_IDX4:   return 8;
      DK_IDX8:   return 4;
      DK_WORD:   return 1;
      default:   return 2;
    endcase
  endfunction

  AST_PX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready && !frame_start |=> px_valid && $stable(px_data)); // R9

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> hold_valid && lane == '0); // R11

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !px_valid && !hold_valid && in_ready); // R11

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && !frame_start |=> $stable(active_kind)); // R10

  AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> int'(lane) < int'(lanes_of(active_kind))); // R2

endmodule

bind pixel_unpacker pixel_unpacker_chk #(.PIX_W(PIX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .px_valid    (px_valid),
  .px_ready    (px_ready),
  .px_data     (px_data),
  .hold_valid  (hold_valid),
  .lane        (lane),
  .idle        (idle),
  .active_kind (active_kind)
);

// File: tb/pixel_unpacker_bench.sv
`timescale 1ns/1ps
module pixel_unpacker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_bpp = '0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = '0;
  logic [15:0] pal_data = '0;
  logic        px_valid;
  logic        px_ready = 1'b1;
  logic [23:0] px_data;

  always #4 clk = ~clk;

  pixel_unpacker u_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bpp(cfg_bpp),
    .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pal_we(pal_we), .pal_addr(pal_addr), .pal_data(pal_data),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [23:0] got [64];
  int ngot = 0;

  typedef struct packed {
    logic [5:0]  bpp;
    logic [31:0] word;
    logic [5:0]  cnt;
    logic [23:0] first;
    logic [23:0] last;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{6'd16, 32'hBEEF1234, 6'd2,  24'h001234, 24'h00BEEF},
    '{6'd8,  32'h040302FF, 6'd4,  24'h005AFF, 24'h00A104},
    '{6'd4,  32'h80000007, 6'd8,  24'h00A207, 24'h00AD08},
    '{6'd2,  32'hC0000002, 6'd16, 24'h00A702, 24'h00A603},
    '{6'd1,  32'h80000001, 6'd32, 24'h00A401, 24'h00A401},
    '{6'd24, 32'hFF123456, 6'd1,  24'h123456, 24'h123456},
    '{6'd32, 32'h00ABCDEF, 6'd1,  24'hABCDEF, 24'hABCDEF},
    '{6'd15, 32'h83E07C1F, 6'd2,  24'h00F81F, 24'h0007E0},
    '{6'd15, 32'h02100200, 6'd2,  24'h000420, 24'h000430},
    '{6'd3,  32'h5555AAAA, 6'd2,  24'h00AAAA, 24'h005555},
    '{6'd0,  32'h00010002, 6'd2,  24'h000002, 24'h000001},
    '{6'd40, 32'h77778888, 6'd2,  24'h008888, 24'h007777},
    '{6'd12, 32'h11112222, 6'd2,  24'h002222, 24'h001111},
    '{6'd17, 32'h0F000001, 6'd1,  24'h000001, 24'h000001}
  };

  // Bench's own colour-table contents.
  function automatic logic [15:0] tbl(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'hA5, b};
  endfunction

  function automatic string req_of(input int b);
    if (b == 1 || b == 2 || b == 4 || b == 8) return "R3";
    if (b == 15) return "R5";
    if (b == 16) return "R4";
    if (b >= 17 && b <= 32) return "R6";
    return "R7";
  endfunction

  function automatic logic [23:0] model_px(input int b, input logic [31:0] w, input int k);
    logic [15:0] h;
    if (b == 1 || b == 2 || b == 4 || b == 8)
      return {8'h00, tbl(int'((w >> (k * b)) % (32'd1 << b)))};
    if (b >= 17 && b <= 32) return w[23:0];
    h = (k == 0) ? w[15:0] : w[31:16];
    if (b == 15) return {8'h00, h[14:10], h[9:5], h[9], h[4:0]};
    return {8'h00, h};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output monitor, sampling 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    if (px_valid && px_ready && ngot < 64) begin
      got[ngot] = px_data;
      ngot++;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_depth(input int b);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_bpp = 6'(b);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  initial begin
    cycles(4);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 px_valid after reset", 32'(px_valid), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);

    // Default mode is 16 bpp.
    ngot = 0;
    push(32'hCAFE0042);
    cycles(6);
    chk("R1 default pixel count", 32'(ngot), 32'd2);
    chk("R1 default first", 32'(got[0]), 32'h000042);
    chk("R1 default second", 32'(got[1]), 32'h00CAFE);

    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pal_we = 1'b1;
      pal_addr = 8'(i);
      pal_data = tbl(i);
    end
    @(negedge clk);
    pal_we = 1'b0;

    // Vector table walk.
    for (int v = 0; v < 14; v++) begin
      int b;
      b = int'(VECS[v].bpp);
      set_depth(b);
      ngot = 0;
      push(VECS[v].word);
      cycles(40);
      chk({"R2 count ", req_of(b)}, 32'(ngot), 32'(VECS[v].cnt));
      chk({req_of(b), " first"}, 32'(got[0]), 32'(VECS[v].first));
      chk({req_of(b), " last"}, 32'(got[VECS[v].cnt - 1]), 32'(VECS[v].last));
      for (int k = 0; k < ngot && k < 32; k++)
        chk({"R2 order ", req_of(b)}, 32'(got[k]), 32'(model_px(b, VECS[v].word, k)));
    end

    // R9 / R11: backpressure at 4 bpp.
    set_depth(4);
    px_ready = 1'b0;
    ngot = 0;
    push(32'h76543210);
    cycles(1);
    #1;
    chk("R9 valid under stall", 32'(px_valid), 32'd1);
    chk("R9 data under stall", 32'(px_data), 32'h00A500);
    cycles(4);
    #1;
    chk("R9 still valid", 32'(px_valid), 32'd1);
    chk("R9 data stable", 32'(px_data), 32'h00A500);
    chk("R11 in_ready low while word held", 32'(in_ready), 32'd0);
    @(negedge clk);
    px_ready = 1'b1;
    cycles(14);
    chk("R9 all pixels after stall", 32'(ngot), 32'd8);
    for (int k = 0; k < 8; k++)
      chk("R9 order after stall", 32'(got[k]), 32'({8'h00, tbl(k)}));

    // R8: write and read of one entry in the same cycle.
    set_depth(8);
    px_ready = 1'b0;
    ngot = 0;
    push(32'h5A5A5A5A);
    @(negedge clk);
    px_ready = 1'b1;
    pal_we = 1'b1;
    pal_addr = 8'h5A;
    pal_data = 16'hBEEF;
    @(negedge clk);
    pal_we = 1'b0;
    cycles(8);
    chk("R8 pixel count", 32'(ngot), 32'd4);
    chk("R8 colliding read gets old", 32'(got[1]), 32'h00FF5A);
    chk("R8 later read gets new", 32'(got[2]), 32'h00BEEF);
    @(negedge clk);
    pal_we = 1'b1;
    pal_data = tbl(8'h5A);
    @(negedge clk);
    pal_we = 1'b0;

    // R11: frame start drops held data.
    set_depth(8);
    px_ready = 1'b0;
    push(32'h44332211);
    cycles(2);
    #1;
    chk("R11 busy before flush", 32'(px_valid), 32'd1);
    pulse_frame();
    #1;
    chk("R11 px_valid after flush", 32'(px_valid), 32'd0);
    chk("R11 in_ready after flush", 32'(in_ready), 32'd1);
    ngot = 0;
    @(negedge clk);
    px_ready = 1'b1;
    cycles(6);
    chk("R11 nothing left after flush", 32'(ngot), 32'd0);

    // R10: depth write while busy waits for frame start.
    set_depth(8);
    px_ready = 1'b0;
    ngot = 0;
    push(32'h08070605);
    cycles(2);
    set_depth(16);
    @(negedge clk);
    px_ready = 1'b1;
    cycles(10);
    chk("R10 busy write ignored count", 32'(ngot), 32'd4);
    chk("R10 busy write ignored data", 32'(got[3]), 32'({8'h00, tbl(8)}));
    ngot = 0;
    push(32'h0C0B0A09);
    cycles(10);
    chk("R10 still old depth", 32'(ngot), 32'd4);
    pulse_frame();
    ngot = 0;
    push(32'h22221111);
    cycles(10);
    chk("R10 depth applied at frame start", 32'(ngot), 32'd2);
    chk("R10 new depth data", 32'(got[0]), 32'h001111);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule